// File: doc/BRIEF.md
# Synchronous Clock Prescaler and Module Mask

This block turns one main clock into single-cycle clock-enable pulses for a group of synchronous domains: domain 0 is the CPU, domain 1 is the high-speed bus, and domains 2 and up are peripheral buses. A free-running 8-bit counter, cleared by reset and incremented every cycle, serves as a shared binary prescaler. Each domain either runs undivided or takes one power-of-two tap of that counter. Each module in a domain has a mask bit that silences its enable. A sleep input silences every enable. The block also holds the index of the main-clock source and switches it only to a source that reports ready.

Configuration uses a single-cycle write port (`cfg_we`, `cfg_addr`, `cfg_wdata`).
- **Address 0** selects the source from `cfg_wdata[1:0]`.
- **Address 1+d** sets the ratio of domain d. Bit 3 is the divide enable and bits 2:0 are the select field. The division exponent is e = SEL+1 when the divide enable is set and e = 0 otherwise.
- **Address 8+d** writes the mask of domain d from `cfg_wdata[MODS-1:0]`. A 1 masks the module.

Enable bit `mod_en[d*MODS+m]` belongs to module m of domain d.

Each domain holds its ratio in a two-state machine. In **ST_RUN** the active ratio drives the enables. An accepted ratio write takes the transition ST_RUN to ST_WAIT and stores the new exponent as pending. A further write in ST_WAIT replaces the pending value. The boundary transition ST_WAIT to ST_RUN fires when the low max(old,new) counter bits are all ones. At that point the pending exponent becomes active.

Top module: `syncclk_ctrl`

## Requirements
- R1: A domain whose divide enable is 0 asserts the enables of its unmasked modules in every cycle.
- R2: A domain with divide enable 1 and select SEL asserts its enables exactly in the cycles where the low SEL+1 bits of the prescaler count are all ones. The count is 0 in the first cycle after reset and increases by one each cycle, so the period is 2^(SEL+1).
- R3: After reset every domain is undivided and unmasked, so `mod_en` is all ones.
- R4: After reset `main_sel` is 0 (the internal RC source), `src_ok` is 1 and `ratio_err` is 0.
- R5: A write to address 0 with index i sets `main_sel` to i and `src_ok` to 1 only when `src_ready[i]` is 1. Otherwise `main_sel` is unchanged and `src_ok` becomes 0.
- R6: A ratio write that would make the CPU exponent larger than any peripheral-bus exponent is refused: the domain keeps its ratio and `ratio_err` becomes 1. An accepted ratio write clears `ratio_err`. The high-speed bus is not constrained.
- R7: A module whose mask bit (address 8+d, 1 = masked) is set gets no enable pulses from the cycle after the write. The other modules of the domain are unaffected.
- R8: While `sleep` is 1, `mod_en` is all zeros. Once `sleep` returns to 0, the configured pattern resumes.
- R9: A ratio change takes effect only at a cycle where both the old and the new enables fire. Every gap between consecutive pulses therefore equals either the old period or the new period, and is never shorter.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Main clock |
| rst | input | 1 | Synchronous active-high reset |
| src_ready | input | NUM_SRC | Ready flag of each main-clock source |
| sleep | input | 1 | Silences every enable while high |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_addr | input | 4 | Configuration address |
| cfg_wdata | input | 8 | Configuration write data |
| main_sel | output | log2(NUM_SRC) | Selected main-clock source index |
| src_ok | output | 1 | Last source write was accepted |
| ratio_err | output | 1 | Last ratio write was refused |
| mod_en | output | (2+NUM_PB)*MODS | Per-module clock-enable pulses |

## Verification
Each enable pattern is compared cycle by cycle against the prescaler count:
- the undivided rate, which tells a missing tap apart from a correct one;
- a /4 tap and the slowest /256 tap, which expose wrong bit selection or off-by-one select decoding;
- a partly masked domain, which separates the per-module mask from the domain-wide ratio.

Ratio changes in both directions (/4 to /64 and back) are watched at the gap level to tell a boundary-aligned switch from an immediate one. Refused and accepted ratio and source writes are mixed so that rule checking is distinguished from blind acceptance.

// File: rtl/syncclk_pkg.sv
package syncclk_pkg;
    localparam int PRE_W     = 8;
    localparam int SEL_W     = 3;
    localparam int EXP_W     = 4;
    localparam int ADDR_W    = 4;
    localparam int DATA_W    = 8;
    localparam int DEN_BIT   = 3;
    localparam int MASK_BASE = 8;

    typedef enum logic {ST_RUN, ST_WAIT} dom_state_t;

    // Low-bit mask selecting the e least significant prescaler bits.
    function automatic logic [PRE_W-1:0] tap_mask(input logic [EXP_W-1:0] e);
        logic [PRE_W:0] sh;
        sh = (PRE_W+1)'(1) << e;
        return PRE_W'(sh - (PRE_W+1)'(1));
    endfunction
endpackage

// File: rtl/syncclk_prescaler.sv
module syncclk_prescaler
    import syncclk_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    output logic [PRE_W-1:0] cnt
);
    always_ff @(posedge clk) begin
        if (rst) cnt <= '0;
        else     cnt <= cnt + 1'b1;
    end
endmodule

// File: rtl/syncclk_domain.sv
module syncclk_domain
    import syncclk_pkg::*;
#(
    parameter int MODS = 4
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [PRE_W-1:0] cnt,
    input  logic             sleep,
    input  logic             ld,
    input  logic [EXP_W-1:0] ld_exp,
    input  logic             mwe,
    input  logic [MODS-1:0]  mdata,
    output logic [EXP_W-1:0] tgt_exp,
    output logic [MODS-1:0]  mod_en
);
    dom_state_t       state, state_n;
    logic [EXP_W-1:0] act, act_n, pend, pend_n, emax;
    logic [MODS-1:0]  mask;
    logic             hit, tick;

    assign emax = (act > pend) ? act : pend;
    assign hit  = (cnt & tap_mask(emax)) == tap_mask(emax);

    // state register
    always_ff @(posedge clk) begin
        if (rst) begin
            state <= ST_RUN;
            act   <= '0;
            pend  <= '0;
        end else begin
            state <= state_n;
            act   <= act_n;
            pend  <= pend_n;
        end
    end

    always_ff @(posedge clk) begin
        if (rst)      mask <= '0;
        else if (mwe) mask <= mdata;
    end

    // transitions
    always_comb begin
        state_n = state;
        act_n   = act;
        pend_n  = pend;
        unique case (state)
            ST_RUN: begin
                if (ld) begin
                    pend_n  = ld_exp;
                    state_n = ST_WAIT;
                end
            end
            ST_WAIT: begin
                if (ld) begin
                    pend_n = ld_exp;
                end else if (hit) begin
                    act_n   = pend;
                    state_n = ST_RUN;
                end
            end
            default: state_n = ST_RUN;
        endcase
    end

    // outputs
    always_comb begin
        tick    = (cnt & tap_mask(act)) == tap_mask(act);
        mod_en  = (tick && !sleep) ? ~mask : '0;
        tgt_exp = (state == ST_WAIT) ? pend : act;
    end

    // gap checker for R9
    logic [PRE_W+1:0] gap;
    logic [EXP_W-1:0] last_exp, mn_exp;
    logic             seen;
    always_ff @(posedge clk) begin
        if (rst) begin
            gap <= '0; last_exp <= '0; seen <= 1'b0;
        end else if (tick) begin
            gap <= '0; last_exp <= act; seen <= 1'b1;
        end else if (gap != (PRE_W+2)'(511)) begin
            gap <= gap + 1'b1;
        end
    end
    assign mn_exp = (last_exp < act) ? last_exp : act;

    assert_no_short_gap_R9: assert property (@(posedge clk) disable iff (rst)
        (tick && seen) |-> ((gap + 1'b1) >= ((PRE_W+2)'(1) << mn_exp)));

    assert_mask_quiet_R7: assert property (@(posedge clk) disable iff (rst)
        (mwe && mdata[0]) |=> !mod_en[0]);
endmodule

// File: rtl/syncclk_ctrl.sv
module syncclk_ctrl
    import syncclk_pkg::*;
#(
    parameter int NUM_PB  = 2,
    parameter int MODS    = 4,
    parameter int NUM_SRC = 4,
    localparam int NDOM   = 2 + NUM_PB,
    localparam int SRC_W  = (NUM_SRC > 1) ? $clog2(NUM_SRC) : 1
) (
    input  logic                   clk,
    input  logic                   rst,
    input  logic [NUM_SRC-1:0]     src_ready,
    input  logic                   sleep,
    input  logic                   cfg_we,
    input  logic [ADDR_W-1:0]      cfg_addr,
    input  logic [DATA_W-1:0]      cfg_wdata,
    output logic [SRC_W-1:0]       main_sel,
    output logic                   src_ok,
    output logic                   ratio_err,
    output logic [NDOM*MODS-1:0]   mod_en
);
    logic [PRE_W-1:0] cnt;
    logic [EXP_W-1:0] tgt [NDOM];
    logic [EXP_W-1:0] new_e;
    logic [NDOM-1:0]  ok_vec, rsel, msel;
    logic             rat_wr, rat_ok, src_wr;
    logic [SRC_W-1:0] src_idx;

    syncclk_prescaler u_pre (.clk(clk), .rst(rst), .cnt(cnt));

    assign new_e = cfg_wdata[DEN_BIT] ? (EXP_W'(cfg_wdata[SEL_W-1:0]) + 1'b1) : '0;

    always_comb begin
        for (int d = 0; d < NDOM; d++) begin
            rsel[d] = cfg_we && (cfg_addr == ADDR_W'(1 + d));
            msel[d] = cfg_we && (cfg_addr == ADDR_W'(MASK_BASE + d));
            if (d == 0) begin
                ok_vec[d] = 1'b1;
                for (int p = 2; p < NDOM; p++)
                    if (tgt[p] < new_e) ok_vec[d] = 1'b0;
            end else if (d == 1) begin
                ok_vec[d] = 1'b1;
            end else begin
                ok_vec[d] = (new_e >= tgt[0]);
            end
        end
        rat_wr = |rsel;
        rat_ok = |(rsel & ok_vec);
    end

    generate
        for (genvar d = 0; d < NDOM; d++) begin : g_dom
            syncclk_domain #(.MODS(MODS)) u_dom (
                .clk(clk), .rst(rst), .cnt(cnt), .sleep(sleep),
                .ld(rsel[d] && ok_vec[d]), .ld_exp(new_e),
                .mwe(msel[d]), .mdata(cfg_wdata[MODS-1:0]),
                .tgt_exp(tgt[d]), .mod_en(mod_en[d*MODS +: MODS])
            );
        end
        for (genvar p = 2; p < NDOM; p++) begin : g_rule
            assert_cpu_not_slower_R6: assert property (@(posedge clk) disable iff (rst)
                tgt[0] <= tgt[p]);
        end
    endgenerate

    assign src_wr  = cfg_we && (cfg_addr == '0);
    assign src_idx = cfg_wdata[SRC_W-1:0];

    always_ff @(posedge clk) begin
        if (rst) begin
            main_sel  <= '0;
            src_ok    <= 1'b1;
            ratio_err <= 1'b0;
        end else begin
            if (src_wr) begin
                if (src_ready[src_idx]) begin
                    main_sel <= src_idx;
                    src_ok   <= 1'b1;
                end else begin
                    src_ok   <= 1'b0;
                end
            end
            if (rat_wr) ratio_err <= !rat_ok;
        end
    end

    assert_src_ready_R5: assert property (@(posedge clk) disable iff (rst)
        (src_wr && !src_ready[src_idx]) |=> ($stable(main_sel) && !src_ok));

    assert_sleep_quiet_R8: assert property (@(posedge clk) disable iff (rst)
        sleep |-> (mod_en == '0));
endmodule

// File: tb/syncclk_ctrl_test.sv
module syncclk_ctrl_test;
    localparam int NDOM = 4;
    localparam int MODS = 4;
    localparam int NB   = NDOM * MODS;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic [3:0]    src_ready = 4'b0001;
    logic          slp = 1'b0;
    logic          cfg_we = 1'b0;
    logic [3:0]    cfg_addr = '0;
    logic [7:0]    cfg_wdata = '0;
    logic [1:0]    main_sel;
    logic          src_ok, ratio_err;
    logic [NB-1:0] mod_en;

    int checks = 0;
    int errors = 0;
    logic [7:0] m;
    int e_tb [NDOM];
    logic [MODS-1:0] mk_tb [NDOM];

    typedef struct {
        logic [NB-1:0] exp_v;
        string         tag;
    } item_t;
    item_t sb[$];

    always #2.5 clk = ~clk;

    syncclk_ctrl uut (
        .clk(clk), .rst(rst), .src_ready(src_ready), .sleep(slp),
        .cfg_we(cfg_we), .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata),
        .main_sel(main_sel), .src_ok(src_ok), .ratio_err(ratio_err),
        .mod_en(mod_en)
    );

    // prescaler count as defined in R2
    always @(posedge clk) m <= rst ? 8'd0 : m + 8'd1;

    function automatic logic [NB-1:0] model_vec();
        logic [NB-1:0] v;
        logic [7:0] tm;
        v = '0;
        for (int d = 0; d < NDOM; d++) begin
            tm = 8'((9'd1 << e_tb[d]) - 9'd1);
            for (int k = 0; k < MODS; k++)
                v[d*MODS+k] = !slp && !mk_tb[d][k] && ((m & tm) == tm);
        end
        return v;
    endfunction

    // monitor
    always @(negedge clk) begin
        if (sb.size() > 0) begin
            item_t it;
            it = sb.pop_front();
            checks++;
            if (mod_en !== it.exp_v) begin
                errors++;
                $display("FAIL %s mod_en=%h expected %h", it.tag, mod_en, it.exp_v);
            end
        end
    end

    task automatic push_cycles(input int n, input string tag);
        item_t it;
        repeat (n) begin
            @(posedge clk); #1;
            it.exp_v = model_vec();
            it.tag   = tag;
            sb.push_back(it);
        end
        @(negedge clk); #0.5;
    endtask

    task automatic wr(input logic [3:0] a, input logic [7:0] d);
        @(posedge clk); #1;
        cfg_we = 1'b1; cfg_addr = a; cfg_wdata = d;
        @(posedge clk); #1;
        cfg_we = 1'b0;
    endtask

    task automatic settle();
        repeat (300) @(posedge clk);
    endtask

    task automatic check_val(input string tag, input int act, input int expv);
        checks++;
        if (act != expv) begin
            errors++;
            $display("FAIL %s actual %0d expected %0d", tag, act, expv);
        end
    endtask

    task automatic gap_check(input int b, input int pa, input int pb, input string tag);
        int last;
        bit saw;
        last = -1;
        saw  = 1'b0;
        for (int i = 0; i < 400; i++) begin
            @(negedge clk);
            if (mod_en[b]) begin
                if (last >= 0) begin
                    checks++;
                    if ((i - last) != pa && (i - last) != pb) begin
                        errors++;
                        $display("FAIL %s gap actual %0d expected %0d or %0d", tag, i - last, pa, pb);
                    end
                    if ((i - last) == pb) saw = 1'b1;
                end
                last = i;
            end
        end
        check_val({tag, " new period seen"}, int'(saw), 1);
    endtask

    task automatic finish_run();
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired");
        finish_run();
    end

    initial begin
        for (int d = 0; d < NDOM; d++) begin
            e_tb[d] = 0;
            mk_tb[d] = '0;
        end
        repeat (5) @(posedge clk);
        #1 rst = 1'b0;

        // R3 / R1: reset pattern, everything undivided
        push_cycles(8, "R3 R1 reset undivided");
        check_val("R4 main_sel", main_sel, 0);
        check_val("R4 src_ok", src_ok, 1);
        check_val("R4 ratio_err", ratio_err, 0);

        // R2: HSB /4 (den=1, sel=1)
        wr(4'd2, 8'h09);
        settle();
        e_tb[1] = 2;
        push_cycles(32, "R2 hsb div4");

        // R2: PB0 /256 (sel=7)
        wr(4'd3, 8'h0F);
        settle();
        e_tb[2] = 8;
        push_cycles(300, "R2 pb0 div256");

        // R7: mask modules 0 and 2 of HSB
        wr(4'd9, 8'h05);
        mk_tb[1] = 4'b0101;
        push_cycles(16, "R7 mask");

        // R5: source switching
        src_ready = 4'b0010;
        wr(4'd0, 8'h02);
        check_val("R5 rejected main_sel", main_sel, 0);
        check_val("R5 rejected src_ok", src_ok, 0);
        wr(4'd0, 8'h01);
        check_val("R5 accepted main_sel", main_sel, 1);
        check_val("R5 accepted src_ok", src_ok, 1);

        // R6: ratio rule
        wr(4'd1, 8'h08);                 // CPU /2 while PB1 undivided
        check_val("R6 cpu refused err", ratio_err, 1);
        settle();
        push_cycles(16, "R6 cpu unchanged");
        wr(4'd4, 8'h0A);                 // PB1 /8
        check_val("R6 pb1 accepted err", ratio_err, 0);
        wr(4'd1, 8'h09);                 // CPU /4
        check_val("R6 cpu accepted err", ratio_err, 0);
        settle();
        e_tb[3] = 3;
        e_tb[0] = 2;
        push_cycles(32, "R6 accepted ratios");
        wr(4'd4, 8'h00);                 // PB1 faster than CPU
        check_val("R6 pb1 refused err", ratio_err, 1);
        settle();
        push_cycles(32, "R6 pb1 unchanged");

        // R8: sleep
        #1 slp = 1'b1;
        push_cycles(16, "R8 asleep");
        slp = 1'b0;
        push_cycles(16, "R8 wake");

        // R9: boundary-aligned changes on HSB module 1
        wr(4'd2, 8'h0D);                 // /4 -> /64
        gap_check(1*MODS + 1, 4, 64, "R9 slow down");
        e_tb[1] = 6;
        wr(4'd2, 8'h09);                 // /64 -> /4
        gap_check(1*MODS + 1, 64, 4, "R9 speed up");
        e_tb[1] = 2;
        settle();
        push_cycles(16, "R9 after change");

        finish_run();
    end
endmodule